// File: doc/BRIEF.md
# SD/MMC Host Interrupt Status Unit

This unit collects the event pulses produced by the command engine and the data engine of an SD/MMC host controller and turns them into a readable status word and one interrupt request line. Each event bit is captured only when software has enabled its status capture. The interrupt line is raised from the captured bits that are also enabled in a second, independent mask. Software clears a flag by writing 1 to its position. An error summary bit is derived from the individual error flags, so clearing only the command flags does not hide a pending data error.

The unit also keeps the two present-state inhibit flags that gate command issue. It owns a self-timing soft-reset control for each line. Writing 1 to a line's reset bit makes that bit read 1 for a fixed number of cycles and then 0. While the bit reads 1, that line's flags and inhibit are held clear and its events are dropped. The engines and the data buffer lie outside the unit.

Register writes use a 2-bit select. The encodings are 0 = status (write 1 to clear), 1 = status-capture enable, 2 = interrupt-signal enable, and 3 = line reset (bit 0 command line, bit 1 data line).

Top module: `sdhost_irq_status`

## Requirements
- R1: After reset, the status word is 0, the capture enable reads 16'hFFFF, the signal enable reads 0, `irq` is 0, both line-reset bits read 0 and both inhibits are 0.
- R2: The status bit positions are: 0 command done, 1 transfer done, 2 read-buffer ready, 3 write-buffer ready, 8 command timeout, 9 command CRC, 10 command end-bit, 11 command index, 12 data timeout, 13 data CRC, 14 data end-bit, 15 error summary. The event inputs map as follows: `cmd_evt[0..4]` to done, timeout, CRC, end-bit and index; `dat_evt[0..5]` to transfer done, read ready, write ready, timeout, CRC and end-bit. An event sets its bit at the next clock edge only when the matching capture-enable bit is 1, and the bit then stays set.
- R3: A write to select 0 clears every flag whose data bit is 1 and leaves the others unchanged. An event on the same cycle as the clear of its bit wins, so the bit stays set.
- R4: Bit 15 reads 1 exactly while any of bits 8 to 14 is set. Writing 1 to bit 15 has no effect, and bit 15 returns to 0 once all error flags are cleared.
- R5: Clearing the command flags (mask 16'h0F01) leaves the data flags, and the summary bit caused by a data error, unchanged.
- R6: `irq` is the OR of the status bits ANDed with the signal-enable mask. This includes bit 15, and `irq` follows the status word in the same cycle.
- R7: Writing 1 to a bit of select 3 makes the matching `line_rst` bit read 1 for RST_CYCLES cycles after the write edge, and then 0. Writing 0 has no effect.
- R8: From the write edge until `line_rst` falls, the reset line's flags (command mask 16'h0F01, data mask 16'h700E) and its inhibit read 0 and its events are ignored. The other line's flags are kept.
- R9: `issue_ack` equals `issue_req` while neither inhibit is set and no line reset is starting or running. An accepted issue sets `cmd_inhibit`, and also sets `dat_inhibit` when `issue_data` is 1.
- R10: `cmd_inhibit` clears on a command done or command timeout event. `dat_inhibit` clears on a transfer done event or any data error event, and these events clear it whatever the capture enable holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_evt | input | 5 | Command engine event pulses |
| dat_evt | input | 6 | Data engine event pulses |
| issue_req | input | 1 | Request to issue a command |
| issue_data | input | 1 | The requested command uses the data line |
| issue_ack | output | 1 | Command issue accepted this cycle |
| cmd_inhibit | output | 1 | Command line busy |
| dat_inhibit | output | 1 | Data line busy |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| status | output | 16 | Status word including error summary |
| stat_en_q | output | 16 | Status-capture enable mask |
| sig_en_q | output | 16 | Interrupt-signal enable mask |
| line_rst | output | 2 | Soft-reset in progress, bit 0 command, bit 1 data |
| irq | output | 1 | Interrupt request |

## Verification
Single command and data events are driven with capture enabled and with it disabled, which separates capture gating from plain latching. Partial write-one-to-clear masks, and clears that collide with a new event, show apart the per-bit clear and the set priority. A data error held across a command-flag clear shows that the summary bit is derived rather than stored with the command flags. Line resets are started while both lines hold flags and inhibits, and the state is sampled inside the reset window and at its last edge, which tells the per-line scope and the exact duration apart.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
   localparam int STAT_W    = 16;
   localparam int CMD_EVT_W = 5;
   localparam int DAT_EVT_W = 6;

   localparam int B_CMD_DONE  = 0;
   localparam int B_XFER_DONE = 1;
   localparam int B_RD_RDY    = 2;
   localparam int B_WR_RDY    = 3;
   localparam int B_CMD_TMO   = 8;
   localparam int B_CMD_CRC   = 9;
   localparam int B_CMD_END   = 10;
   localparam int B_CMD_IDX   = 11;
   localparam int B_DAT_TMO   = 12;
   localparam int B_DAT_CRC   = 13;
   localparam int B_DAT_END   = 14;
   localparam int B_ERR_SUM   = 15;

   localparam logic [STAT_W-1:0] CMD_MASK = 16'h0F01;
   localparam logic [STAT_W-1:0] DAT_MASK = 16'h700E;
   localparam logic [STAT_W-1:0] ERR_MASK = 16'h7F00;

   typedef enum logic [1:0] {
      SEL_STAT     = 2'd0,
      SEL_STAT_EN  = 2'd1,
      SEL_SIG_EN   = 2'd2,
      SEL_LINE_RST = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irqs_flag_bank.sv
module irqs_flag_bank #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   input  logic [W-1:0] hold_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_width
         $error("irqs_flag_bank: W must be at least 1");
      end
      for (genvar b = 0; b < W; b++) begin : g_bit
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          r <= 1'b0;
            else if (hold_i[b])  r <= 1'b0;
            else if (set_i[b])   r <= 1'b1;
            else if (clr_i[b])   r <= 1'b0;
         end
         assign q_o[b] = r;
      end
   endgenerate
endmodule

// File: rtl/irqs_line_reset.sv
module irqs_line_reset #(
   parameter int CYCLES = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("irqs_line_reset: CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (start_i && cnt == '0)    cnt <= CW'(CYCLES);
      else if (cnt != '0)               cnt <= cnt - 1'b1;
   end

   assign busy_o = (cnt != '0);
endmodule

// File: rtl/sdhost_irq_status.sv
module sdhost_irq_status
   import irqs_pkg::*;
#(
   parameter int                RST_CYCLES   = 6,
   parameter logic [STAT_W-1:0] STAT_EN_INIT = 16'hFFFF,
   parameter bit                IRQ_REG      = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CMD_EVT_W-1:0] cmd_evt,
   input  logic [DAT_EVT_W-1:0] dat_evt,
   input  logic                 issue_req,
   input  logic                 issue_data,
   output logic                 issue_ack,
   output logic                 cmd_inhibit,
   output logic                 dat_inhibit,
   input  logic                 wr_en,
   input  logic [1:0]           wr_addr,
   input  logic [STAT_W-1:0]    wr_data,
   output logic [STAT_W-1:0]    status,
   output logic [STAT_W-1:0]    stat_en_q,
   output logic [STAT_W-1:0]    sig_en_q,
   output logic [1:0]           line_rst,
   output logic                 irq
);
   localparam logic [STAT_W-1:0] SUM_BIT = STAT_W'(1) << B_ERR_SUM;

   logic [STAT_W-1:0] raw_set, set_vec, clr_vec, hold_vec, flags;
   logic              wr_stat, wr_sen, wr_gen;
   logic              cmd_start, dat_start, cmd_busy, dat_busy;
   logic              cmd_hold, dat_hold, err_sum, irq_raw;
   logic              cmd_end_evt, dat_end_evt;
   logic              cmd_inh_r, dat_inh_r;

   assign wr_stat   = wr_en && (wr_addr == SEL_STAT);
   assign wr_sen    = wr_en && (wr_addr == SEL_STAT_EN);
   assign wr_gen    = wr_en && (wr_addr == SEL_SIG_EN);
   assign cmd_start = wr_en && (wr_addr == SEL_LINE_RST) && wr_data[0];
   assign dat_start = wr_en && (wr_addr == SEL_LINE_RST) && wr_data[1];

   irqs_line_reset #(.CYCLES(RST_CYCLES)) u_cmd_rst (
      .clk(clk), .rst_n(rst_n), .start_i(cmd_start), .busy_o(cmd_busy));
   irqs_line_reset #(.CYCLES(RST_CYCLES)) u_dat_rst (
      .clk(clk), .rst_n(rst_n), .start_i(dat_start), .busy_o(dat_busy));

   assign cmd_hold = cmd_start | cmd_busy;
   assign dat_hold = dat_start | dat_busy;
   assign line_rst = {dat_busy, cmd_busy};

   always_comb begin
      raw_set              = '0;
      raw_set[B_CMD_DONE]  = cmd_evt[0];
      raw_set[B_CMD_TMO]   = cmd_evt[1];
      raw_set[B_CMD_CRC]   = cmd_evt[2];
      raw_set[B_CMD_END]   = cmd_evt[3];
      raw_set[B_CMD_IDX]   = cmd_evt[4];
      raw_set[B_XFER_DONE] = dat_evt[0];
      raw_set[B_RD_RDY]    = dat_evt[1];
      raw_set[B_WR_RDY]    = dat_evt[2];
      raw_set[B_DAT_TMO]   = dat_evt[3];
      raw_set[B_DAT_CRC]   = dat_evt[4];
      raw_set[B_DAT_END]   = dat_evt[5];
   end

   assign set_vec  = raw_set & stat_en_q & ~SUM_BIT;
   assign clr_vec  = wr_stat ? wr_data : '0;
   assign hold_vec = ({STAT_W{cmd_hold}} & CMD_MASK) | ({STAT_W{dat_hold}} & DAT_MASK) | SUM_BIT;

   irqs_flag_bank #(.W(STAT_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec),
      .hold_i(hold_vec), .q_o(flags));

   assign err_sum = |(flags & ERR_MASK);
   assign status  = (flags & ~SUM_BIT) | (err_sum ? SUM_BIT : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_en_q <= STAT_EN_INIT;
         sig_en_q  <= '0;
      end else begin
         if (wr_sen) stat_en_q <= wr_data;
         if (wr_gen) sig_en_q  <= wr_data;
      end
   end

   assign irq_raw = |(status & sig_en_q);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate

   assign cmd_end_evt = cmd_evt[0] | cmd_evt[1];
   assign dat_end_evt = dat_evt[0] | dat_evt[3] | dat_evt[4] | dat_evt[5];
   assign issue_ack   = issue_req & ~cmd_inh_r & ~dat_inh_r & ~cmd_hold & ~dat_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_inh_r <= 1'b0;
         dat_inh_r <= 1'b0;
      end else begin
         if (cmd_hold)                      cmd_inh_r <= 1'b0;
         else if (issue_ack)                cmd_inh_r <= 1'b1;
         else if (cmd_end_evt)              cmd_inh_r <= 1'b0;
         if (dat_hold)                      dat_inh_r <= 1'b0;
         else if (issue_ack && issue_data)  dat_inh_r <= 1'b1;
         else if (dat_end_evt)              dat_inh_r <= 1'b0;
      end
   end

   assign cmd_inhibit = cmd_inh_r;
   assign dat_inhibit = dat_inh_r;
endmodule

// File: rtl/irqs_chk.sv
module irqs_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [4:0]  cmd_evt,
   input logic [5:0]  dat_evt,
   input logic        issue_ack,
   input logic        cmd_inhibit,
   input logic        dat_inhibit,
   input logic        wr_en,
   input logic [1:0]  wr_addr,
   input logic [15:0] wr_data,
   input logic [15:0] status,
   input logic [15:0] stat_en_q,
   input logic [15:0] sig_en_q,
   input logic [1:0]  line_rst,
   input logic        irq
);
   // R2: a bit whose capture is disabled cannot rise
   a_r2_masked_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[2] && !stat_en_q[2]) |=> !status[2]);

   // R3: write-one-to-clear with no colliding event
   a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd0 && wr_data[1] && !dat_evt[0]) |=> !status[1]);

   // R4: summary cannot appear without an error event
   a_r4_sum_needs_error: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[15] && !(|dat_evt[5:3]) && !(|cmd_evt[4:1])) |=> !status[15]);

   // R6: nothing enabled, no interrupt
   a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_en_q == 16'h0) |-> !irq);

   // R7: a line reset only begins after a write of 1
   a_r7_rst_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_rst[0]) |-> $past(wr_en && wr_addr == 2'd3 && wr_data[0]));

   // R8: data flags and inhibit held clear during data line reset
   a_r8_dat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      line_rst[1] |-> ((status & 16'h700E) == 16'h0 && !dat_inhibit));

   // R9: accepted issue only when idle, and it sets the command inhibit
   a_r9_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
      issue_ack |-> (!cmd_inhibit && !dat_inhibit));
   a_r9_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
      issue_ack |=> cmd_inhibit);
endmodule

bind sdhost_irq_status irqs_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_evt(cmd_evt), .dat_evt(dat_evt),
   .issue_ack(issue_ack), .cmd_inhibit(cmd_inhibit), .dat_inhibit(dat_inhibit),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .status(status),
   .stat_en_q(stat_en_q), .sig_en_q(sig_en_q), .line_rst(line_rst), .irq(irq));

// File: tb/sim_sdhost_irq_status.sv
module sim_sdhost_irq_status;
   localparam int RC = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cmd_evt = '0;
   logic [5:0]  dat_evt = '0;
   logic        issue_req = 1'b0, issue_data = 1'b0;
   logic        issue_ack, cmd_inhibit, dat_inhibit;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] status, stat_en_q, sig_en_q;
   logic [1:0]  line_rst;
   logic        irq;

   sdhost_irq_status #(.RST_CYCLES(RC)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_evt(cmd_evt), .dat_evt(dat_evt),
      .issue_req(issue_req), .issue_data(issue_data), .issue_ack(issue_ack),
      .cmd_inhibit(cmd_inhibit), .dat_inhibit(dat_inhibit),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .status(status), .stat_en_q(stat_en_q), .sig_en_q(sig_en_q),
      .line_rst(line_rst), .irq(irq));

   always #5 clk = ~clk;

   typedef enum int {K_STAT, K_IRQ, K_RST, K_INH, K_ACK, K_SEN, K_GEN} kind_e;
   typedef struct {
      string       tag;
      kind_e       kind;
      logic [15:0] val;
   } item_t;

   item_t sbq[$];
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;

   // monitor: compare queued expectations away from the active edge
   always @(negedge clk) begin
      while (sbq.size() > 0) begin
         item_t it;
         logic [15:0] act;
         it = sbq.pop_front();
         case (it.kind)
            K_STAT:  act = status;
            K_IRQ:   act = {15'd0, irq};
            K_RST:   act = {14'd0, line_rst};
            K_INH:   act = {14'd0, dat_inhibit, cmd_inhibit};
            K_ACK:   act = {15'd0, issue_ack};
            K_SEN:   act = stat_en_q;
            default: act = sig_en_q;
         endcase
         checks++;
         if (act !== it.val) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.val);
         end
      end
   end

   task automatic expect_v(input kind_e k, input logic [15:0] v, input string tag);
      item_t it;
      it.tag = tag; it.kind = k; it.val = v;
      sbq.push_back(it);
   endtask

   task automatic cyc();
      @(posedge clk); #2;
      cmd_evt = '0; dat_evt = '0; wr_en = 1'b0;
      issue_req = 1'b0; issue_data = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      cyc();
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1 reset state
      expect_v(K_STAT, 16'h0000, "R1 status");
      expect_v(K_SEN,  16'hFFFF, "R1 stat_en");
      expect_v(K_GEN,  16'h0000, "R1 sig_en");
      expect_v(K_IRQ,  16'h0,    "R1 irq");
      expect_v(K_RST,  16'h0,    "R1 line_rst");
      expect_v(K_INH,  16'h0,    "R1 inhibit");
      cyc();

      // R2 capture with enable on
      cmd_evt[0] = 1'b1; cyc();
      expect_v(K_STAT, 16'h0001, "R2 cmd done latched");
      cyc();
      expect_v(K_STAT, 16'h0001, "R2 flag persists");
      // R2 capture disabled for read-ready
      wr(2'd1, 16'hFFFB);
      expect_v(K_SEN, 16'hFFFB, "R2 stat_en readback");
      dat_evt[1] = 1'b1; cyc();
      expect_v(K_STAT, 16'h0001, "R2 masked event ignored");
      wr(2'd1, 16'hFFFF);

      // R3 write-one-to-clear
      wr(2'd0, 16'h0001);
      expect_v(K_STAT, 16'h0000, "R3 clear");
      cmd_evt[0] = 1'b1; dat_evt[0] = 1'b1; cyc();
      expect_v(K_STAT, 16'h0003, "R2 two flags");
      wr(2'd0, 16'h0002);
      expect_v(K_STAT, 16'h0001, "R3 partial clear");
      cmd_evt[0] = 1'b1; wr(2'd0, 16'h0001);
      expect_v(K_STAT, 16'h0001, "R3 event beats clear");
      wr(2'd0, 16'h0001);
      expect_v(K_STAT, 16'h0000, "R3 clear after collision");

      // R4 / R5 error summary
      dat_evt[4] = 1'b1; cyc();
      expect_v(K_STAT, 16'hA000, "R4 summary with data crc");
      cmd_evt[0] = 1'b1; cmd_evt[1] = 1'b1; cyc();
      expect_v(K_STAT, 16'hA101, "R4 cmd timeout added");
      wr(2'd0, 16'h0F01);
      expect_v(K_STAT, 16'hA000, "R5 cmd clear keeps data and summary");
      wr(2'd0, 16'h8000);
      expect_v(K_STAT, 16'hA000, "R4 summary write ignored");
      wr(2'd0, 16'h2000);
      expect_v(K_STAT, 16'h0000, "R4 summary self clears");

      // R6 interrupt line
      dat_evt[0] = 1'b1; cyc();
      expect_v(K_IRQ, 16'h0, "R6 no enable no irq");
      wr(2'd2, 16'h0002);
      expect_v(K_IRQ, 16'h1, "R6 enabled flag raises irq");
      wr(2'd2, 16'h8000);
      expect_v(K_IRQ, 16'h0, "R6 summary enable without error");
      dat_evt[3] = 1'b1; cyc();
      expect_v(K_STAT, 16'h9002, "R4 data timeout summary");
      expect_v(K_IRQ,  16'h1,    "R6 irq via summary");
      wr(2'd0, 16'hFFFF);
      expect_v(K_IRQ, 16'h0, "R6 irq drops after clear");
      wr(2'd2, 16'h0000);

      // R9 / R10 inhibit
      issue_req = 1'b1; issue_data = 1'b1;
      expect_v(K_ACK, 16'h1, "R9 idle issue accepted");
      cyc();
      expect_v(K_INH, 16'h3, "R9 both inhibits set");
      issue_req = 1'b1;
      expect_v(K_ACK, 16'h0, "R9 refused while inhibited");
      cyc();
      cmd_evt[0] = 1'b1; cyc();
      expect_v(K_INH, 16'h2, "R10 cmd done clears cmd inhibit");
      issue_req = 1'b1;
      expect_v(K_ACK, 16'h0, "R9 refused on data inhibit");
      cyc();
      dat_evt[0] = 1'b1; cyc();
      expect_v(K_INH, 16'h0, "R10 transfer done clears data inhibit");
      wr(2'd0, 16'hFFFF);
      issue_req = 1'b1; cyc();
      expect_v(K_INH, 16'h1, "R9 issue without data");
      cmd_evt[1] = 1'b1; cyc();
      expect_v(K_INH,  16'h0,    "R10 timeout clears cmd inhibit");
      expect_v(K_STAT, 16'h8100, "R4 cmd timeout summary");
      wr(2'd0, 16'hFFFF);
      wr(2'd1, 16'h0000);
      dat_evt[4] = 1'b1; issue_req = 1'b1; issue_data = 1'b1; cyc();
      dat_evt[4] = 1'b1; cyc();
      expect_v(K_INH,  16'h1,    "R10 data error clears inhibit while capture off");
      expect_v(K_STAT, 16'h0000, "R2 capture off keeps status clear");
      cmd_evt[0] = 1'b1; cyc();
      wr(2'd1, 16'hFFFF);

      // R7 / R8 data line reset
      cmd_evt[0] = 1'b1; dat_evt[0] = 1'b1; dat_evt[2] = 1'b1;
      issue_req = 1'b1; issue_data = 1'b1; cyc();
      expect_v(K_STAT, 16'h000B, "R2 flags before reset");
      expect_v(K_INH,  16'h3,    "R9 inhibits before reset");
      wr(2'd3, 16'h0002);
      expect_v(K_RST,  16'h2,    "R7 data reset reads 1");
      expect_v(K_STAT, 16'h0001, "R8 data flags cleared cmd kept");
      expect_v(K_INH,  16'h1,    "R8 data inhibit cleared");
      dat_evt[0] = 1'b1; cyc();
      expect_v(K_STAT, 16'h0001, "R8 event ignored during reset");
      issue_req = 1'b1;
      expect_v(K_ACK, 16'h0, "R9 refused during reset");
      cyc();
      repeat (RC - 3) cyc();
      expect_v(K_RST, 16'h2, "R7 still resetting at last cycle");
      cyc();
      expect_v(K_RST, 16'h0, "R7 data reset self clears");
      dat_evt[0] = 1'b1; cyc();
      expect_v(K_STAT, 16'h0003, "R8 events accepted after reset");
      wr(2'd3, 16'h0000);
      expect_v(K_RST,  16'h0,    "R7 write of zero no effect");
      expect_v(K_STAT, 16'h0003, "R7 zero write keeps flags");

      // R8 command line reset
      wr(2'd3, 16'h0001);
      expect_v(K_RST,  16'h1,    "R7 cmd reset reads 1");
      expect_v(K_STAT, 16'h0002, "R8 cmd flags cleared data kept");
      expect_v(K_INH,  16'h0,    "R8 cmd inhibit cleared");
      repeat (RC - 1) cyc();
      expect_v(K_RST, 16'h1, "R7 cmd reset last cycle");
      cyc();
      expect_v(K_RST, 16'h0, "R7 cmd reset done");
      cyc();
      cyc();

      done = 1'b1;
      finish_run();
   end
endmodule